// File: doc/BRIEF.md
# Serial Management Slave with All-Register Burst

This block is the management-port end of a four-channel line device. It is clocked by the serial management clock MDC. It watches the MDIO data line, which arrives here split into an input, a driven value and a drive enable. After a long run of ones the port is idle. A start pattern then opens a frame, and the block decodes a header that carries the opcode, the device address and the register address. It then moves one 16-bit word into or out of a small register bank. The bank holds eleven registers for each of four channels. The upper device-address bits must match a configured base, and the two low bits pick the channel.

When the `burst_en` input is high, a reserved register address turns a frame into a burst. That single frame then streams every register of every channel, which is 704 data bits. Words go in ascending register order within a channel, and channel 0 comes first. After any frame, a fresh idle run is required before the port will accept another start.

Top module: `mdio_burst_slave`

## Requirements
- R1: After reset `mdio_oe` is 0. A frame can only start once 32 consecutive 1 samples have been taken on `mdio_i` after reset or after the previous frame; 31 ones followed by a start pattern are not decoded.
- R2: From idle, a sample of 0 followed by a sample of 1 starts a frame. The 14 header bits follow MSB first: opcode (2 bits, 10 = read, 01 = write, other values ignored with no drive and no write), device address (5 bits), register address (5 bits), turnaround (2 bits).
- R3: `mdio_oe` stays 0 through the preamble, the start pattern and the first turnaround bit. On an accepted read, the block drives 0 for the second turnaround bit and never drives on a write.
- R4: A single read returns the addressed register, MSB first, one bit per MDC cycle. Each bit is updated just after a rising edge, so it is stable at the next rising edge.
- R5: A single write shifts in 16 bits MSB first and stores them into the addressed register at the last data edge.
- R6: A frame is accepted only when device-address bits [4:2] equal the base address bits (default base 4, i.e. addresses 4 to 7). Address bits [1:0] select the channel. A mismatching frame is never driven and writes nothing.
- R7: The implemented register addresses are 0, 1, 2, 3, 4, 5, 6, 16, 17, 18 and 20. A single read of any other address returns 0, and a single write to one changes no register.
- R8: At the end of each frame the drive enable drops and stays low until a new frame is accepted after a fresh idle run.
- R9: With `burst_en` high, register address 31 selects a burst of 44 words. On a write, word n lands in channel n/11 at the (n mod 11)-th implemented address in ascending order.
- R10: With `burst_en` low, address 31 is an unimplemented address: 16 data bits, reads 0, writes ignored.
- R11: A burst read drives all 44 words in the order of R9 and releases the line after the 704th data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_en | input | 1 | Global enable for the all-register burst address |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line; 0 means high impedance |

## Verification
The bench aims at the idle counter's boundary by offering a start after only 31 ones. A counter that was off by one would answer that frame by driving the line. It checks the turnaround slot exactly: a slave that turned on a cycle late would lose the 0 there, and one that turned on early would fight the master during the first turnaround bit. Unimplemented and reserved addresses are probed with burst mode off, where a wrong decode would alias writes into real registers or stretch the frame. Full 704-bit bursts in both directions are compared word by word against a model, so any slip in the channel/register walk shows up as a permuted register.

// File: rtl/mdio_burst_slave.sv
module mdio_burst_slave #(
  parameter int N_CH = 4,
  parameter int N_REG = 11,
  parameter int DW = 16,
  parameter int IDLE_ONES = 32,
  parameter logic [4:0] PHY_BASE = 5'd4,
  parameter logic [4:0] BURST_ADDR = 5'd31,
  parameter logic [N_REG*5-1:0] REG_LIST =
    {5'd20, 5'd18, 5'd17, 5'd16, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}
) (
  input  logic mdc,
  input  logic rst_n,
  input  logic burst_en,
  input  logic mdio_i,
  output logic mdio_o,
  output logic mdio_oe
);
  localparam int CHW = $clog2(N_CH);
  localparam int RIW = $clog2(N_REG);
  localparam int BW = $clog2(DW);
  localparam int OW = $clog2(IDLE_ONES + 1);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_START, S_HDR, S_DATA} st_t;

  st_t st;
  logic [OW-1:0] ones;
  logic [3:0] hcnt;
  logic [11:0] hdr;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] sh;
  logic act, rd, bst, hit;
  logic [CHW-1:0] ch;
  logic [RIW-1:0] ri;
  logic [DW-1:0] bank [N_CH][N_REG];

  logic [1:0] op;
  logic [4:0] phy, ra;
  logic match, op_rd, op_wr, lk_hit;
  logic [RIW-1:0] lk_idx;

  assign op = hdr[11:10];
  assign phy = hdr[9:5];
  assign ra = hdr[4:0];
  assign match = phy[4:CHW] == PHY_BASE[4:CHW];
  assign op_rd = op == 2'b10;
  assign op_wr = op == 2'b01;

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int k = 0; k < N_REG; k++)
      if (REG_LIST[k*5 +: 5] == ra) begin
        lk_hit = 1'b1;
        lk_idx = RIW'(k);
      end
  end

  logic last_r, last_w, last_b;
  logic [RIW-1:0] nri;
  logic [CHW-1:0] nch;
  logic [DW-1:0] cur_word, nxt_word, wr_word;

  assign last_r = ri == RIW'(N_REG - 1);
  assign last_w = !bst || (last_r && ch == CHW'(N_CH - 1));
  assign last_b = bcnt == BW'(DW - 1);
  assign nri = last_r ? '0 : ri + 1'b1;
  assign nch = last_r ? ch + 1'b1 : ch;
  assign cur_word = hit ? bank[ch][ri] : '0;
  assign nxt_word = bank[nch][nri];
  assign wr_word = {sh[DW-2:0], mdio_i};

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT;
      ones <= '0;
      hcnt <= '0;
      hdr <= '0;
      bcnt <= '0;
      sh <= '0;
      act <= 1'b0;
      rd <= 1'b0;
      bst <= 1'b0;
      hit <= 1'b0;
      ch <= '0;
      ri <= '0;
      mdio_o <= 1'b0;
      mdio_oe <= 1'b0;
      for (int c = 0; c < N_CH; c++)
        for (int r = 0; r < N_REG; r++)
          bank[c][r] <= '0;
    end else begin
      case (st)
        S_WAIT:
          if (!mdio_i) ones <= '0;
          else if (ones == OW'(IDLE_ONES - 1)) st <= S_IDLE;
          else ones <= ones + 1'b1;
        S_IDLE:
          if (!mdio_i) st <= S_START;
        S_START:
          if (mdio_i) begin
            st <= S_HDR;
            hcnt <= '0;
          end else begin
            st <= S_WAIT;
            ones <= '0;
          end
        S_HDR: begin
          hcnt <= hcnt + 1'b1;
          if (hcnt < 4'd12) hdr <= {hdr[10:0], mdio_i};
          if (hcnt == 4'd12) begin
            act <= match && (op_rd || op_wr);
            rd <= op_rd;
            bst <= burst_en && ra == BURST_ADDR && match && (op_rd || op_wr);
            if (burst_en && ra == BURST_ADDR) begin
              ch <= '0;
              ri <= '0;
              hit <= 1'b1;
            end else begin
              ch <= phy[CHW-1:0];
              ri <= lk_idx;
              hit <= lk_hit;
            end
            if (match && op_rd) begin
              mdio_oe <= 1'b1;
              mdio_o <= 1'b0;
            end
          end
          if (hcnt == 4'd13) begin
            st <= S_DATA;
            bcnt <= '0;
            if (act && rd) begin
              mdio_o <= cur_word[DW-1];
              sh <= {cur_word[DW-2:0], 1'b0};
            end
          end
        end
        S_DATA: begin
          bcnt <= last_b ? '0 : bcnt + 1'b1;
          if (rd) begin
            mdio_o <= sh[DW-1];
            sh <= {sh[DW-2:0], 1'b0};
          end else begin
            sh <= wr_word;
          end
          if (last_b) begin
            if (act && !rd && hit) bank[ch][ri] <= wr_word;
            if (last_w) begin
              st <= S_WAIT;
              ones <= '0;
              mdio_oe <= 1'b0;
            end else begin
              ri <= nri;
              ch <= nch;
              if (act && rd) begin
                mdio_o <= nxt_word[DW-1];
                sh <= {nxt_word[DW-2:0], 1'b0};
              end
            end
          end
        end
        default: st <= S_WAIT;
      endcase
    end
  end
endmodule

module mdio_burst_slave_chk (
  input logic mdc,
  input logic rst_n,
  input logic mdio_i,
  input logic mdio_o,
  input logic mdio_oe,
  input logic [2:0] st,
  input logic act,
  input logic rd
);
  AST_WAIT_RELEASED: assert property (@(posedge mdc) disable iff (!rst_n)
    st == 3'd0 |-> !mdio_oe); // R8
  AST_TA_DRIVES_ZERO: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R3
  AST_DRIVE_ONLY_READ: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (act && rd)); // R6
  AST_IDLE_AFTER_ONE: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == 3'd1 && $past(st) == 3'd0) |-> $past(mdio_i)); // R1
  AST_HDR_AFTER_START: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == 3'd3 && $past(st) != 3'd3) |-> ($past(st) == 3'd2 && $past(mdio_i))); // R2
  AST_RELEASE_TO_WAIT: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> st == 3'd0); // R8
endmodule

bind mdio_burst_slave mdio_burst_slave_chk i_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .st(st), .act(act), .rd(rd)
);

// File: tb/test_mdio_burst_slave.sv
module test_mdio_burst_slave;
  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic burst_en = 1'b0;
  logic mdio_i = 1'b1;
  logic mdio_o, mdio_oe;

  mdio_burst_slave i_mdio_burst_slave (
    .mdc(mdc), .rst_n(rst_n), .burst_en(burst_en),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #4 mdc = ~mdc;

  localparam logic [4:0] LIST [11] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5,
                                       5'd6, 5'd16, 5'd17, 5'd18, 5'd20};
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] model [4][11];
  logic [15:0] wbuf [44];
  logic [15:0] rbuf [44];
  bit hdr_oe, ta_ok, oe_all, oe_any, post_oe;

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic sbit(logic b);
    @(negedge mdc);
    if (mdio_oe !== 1'b0) hdr_oe = 1;
    mdio_i = b;
    @(posedge mdc);
  endtask

  task automatic xfer(logic [1:0] op, logic [4:0] phy, logic [4:0] ra, int nw, int pre);
    hdr_oe = 0; oe_all = 1; oe_any = 0; ta_ok = 0;
    repeat (pre) sbit(1'b1);
    sbit(1'b0); sbit(1'b1);
    for (int i = 1; i >= 0; i--) sbit(op[i]);
    for (int i = 4; i >= 0; i--) sbit(phy[i]);
    for (int i = 4; i >= 0; i--) sbit(ra[i]);
    sbit(1'b1);
    @(negedge mdc);
    ta_ok = (mdio_oe === 1'b1) && (mdio_o === 1'b0);
    mdio_i = 1'b1;
    @(posedge mdc);
    for (int w = 0; w < nw; w++)
      for (int b = 15; b >= 0; b--) begin
        @(negedge mdc);
        rbuf[w][b] = mdio_o;
        if (mdio_oe !== 1'b1) oe_all = 0;
        if (mdio_oe === 1'b1) oe_any = 1;
        mdio_i = (op == 2'b01) ? wbuf[w][b] : 1'b1;
        @(posedge mdc);
      end
    @(negedge mdc);
    post_oe = mdio_oe;
    mdio_i = 1'b0;
  endtask

  function automatic logic [4:0] dev(int c);
    return {3'b001, 2'(c)};
  endfunction

  task automatic read_chk(int c, int k, string req);
    xfer(2'b10, dev(c), LIST[k], 1, 32);
    chk(req, rbuf[0], model[c][k]);
  endtask

  initial begin
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 11; k++) model[c][k] = '0;
    void'($urandom(32'd1357));
    repeat (3) @(posedge mdc);
    @(negedge mdc);
    chk("R1 reset oe", mdio_oe, 0);
    rst_n = 1'b1;

    xfer(2'b10, 5'd4, 5'd0, 1, 20);
    chk("R1 short idle after reset", oe_any, 0);

    for (int it = 0; it < 40; it++) begin
      int c = $urandom % 4;
      int k = $urandom % 11;
      if ($urandom % 2) begin
        wbuf[0] = 16'($urandom);
        xfer(2'b01, dev(c), LIST[k], 1, 32);
        model[c][k] = wbuf[0];
        chk("R3 write no drive", oe_any | hdr_oe, 0);
      end else begin
        xfer(2'b10, dev(c), LIST[k], 1, 32);
        chk("R4 single read", rbuf[0], model[c][k]);
        chk("R3 header released", hdr_oe, 0);
        chk("R3 turnaround zero", ta_ok, 1);
        chk("R8 released at end", post_oe, 0);
      end
    end
    for (int k = 0; k < 11; k++) read_chk(2, k, "R5 write stored");

    wbuf[0] = 16'hdead;
    xfer(2'b01, dev(1), 5'd7, 1, 32);
    xfer(2'b10, dev(1), 5'd7, 1, 32);
    chk("R7 unimplemented reads zero", rbuf[0], 0);
    chk("R7 unimplemented still driven", oe_all, 1);
    for (int k = 0; k < 11; k++) read_chk(1, k, "R7 write ignored");

    wbuf[0] = 16'hbeef;
    xfer(2'b01, 5'd8, LIST[3], 1, 32);
    chk("R6 mismatch write no drive", oe_any, 0);
    read_chk(0, 3, "R6 mismatch write ignored");
    xfer(2'b10, 5'd9, LIST[0], 1, 32);
    chk("R6 mismatch read no drive", oe_any | ta_ok, 0);

    xfer(2'b11, 5'd4, LIST[0], 1, 32);
    chk("R2 bad opcode no drive", oe_any, 0);
    wbuf[0] = 16'h1234;
    xfer(2'b00, 5'd4, LIST[1], 1, 32);
    read_chk(0, 1, "R2 bad opcode no write");

    xfer(2'b10, 5'd4, LIST[2], 1, 31);
    chk("R8 31 ones rejected", oe_any | hdr_oe, 0);
    read_chk(0, 2, "R8 recovery after full idle");

    xfer(2'b10, 5'd5, 5'd31, 1, 32);
    chk("R10 reserved reads zero", rbuf[0], 0);
    chk("R10 reserved drives", oe_all, 1);
    chk("R10 sixteen bits only", post_oe, 0);
    wbuf[0] = 16'hffff;
    xfer(2'b01, 5'd4, 5'd31, 1, 32);
    read_chk(0, 0, "R10 reserved write ignored");
    read_chk(0, 10, "R10 reserved write ignored");

    burst_en = 1'b1;
    for (int w = 0; w < 44; w++) wbuf[w] = 16'($urandom);
    xfer(2'b01, 5'd4, 5'd31, 44, 32);
    for (int w = 0; w < 44; w++) model[w / 11][w % 11] = wbuf[w];
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 11; k++) read_chk(c, k, "R9 burst write order");

    xfer(2'b10, 5'd6, 5'd31, 44, 32);
    for (int w = 0; w < 44; w++)
      chk("R11 burst read word", rbuf[w], model[w / 11][w % 11]);
    chk("R11 driven throughout", oe_all, 1);
    chk("R11 released after 704", post_oe, 0);
    chk("R3 burst turnaround", ta_ok, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule